// File: doc/BRIEF.md
# Protected Top-of-RAM Window Guard

This block filters every memory request on its way to system RAM and hides a protected window at the top of installed memory from code that is not running in system-management mode (SMM). The window base is the RAM size minus a window size. The size comes from a two-bit code in a configuration register. The all-ones code selects a separately parameterised extended size in megabytes.

Two byte-wide configuration registers control the block. The window register holds the size code and the window enable. The control register holds the open, close, lock and global enable bits. A sticky lock bit clears the open bit when it is set. After that, open, the global enable and the whole window register are frozen until a synchronous reset. The close bit stays writable.

Requests carry an address, a read/write flag, write data and an SMM flag. A request that is allowed goes straight to the RAM port, and read data returns combinationally. A request that is blocked never asserts the RAM enable. A blocked read returns 0xFF.

Top module: `smram_guard`

## Requirements
- R1: Control register (cfg_sel=1) layout is bit0 open, bit1 close, bit2 lock, bit3 global enable, bits 7:4 read 0. While unlocked, open reads back exactly the last value written, 0 or 1.
- R2: A control write that sets the lock bit leaves open reading 0 from the next cycle on, whatever value was written to bit0.
- R3: While locked, a control write with bit0 set leaves open at 0.
- R4: Only rst clears the lock. After reset, open is again freely writable.
- R5: Window register (cfg_sel=0) layout is bits 1:0 size code and bit2 window enable, with bits 7:3 reading 0. Size codes are 00 = 1 MB, 01 = 2 MB, 10 = 8 MB and 11 = EXT_MB megabytes.
- R6: The window base is (RAM_MB - size) * 2^20. The byte at base-1 always reaches RAM as an ordinary read/write byte.
- R7: When global enable, window enable and close are all 1, a non-SMM read of any byte from base to the RAM top returns 0xFF. A non-SMM write there does not reach RAM (ram_en stays 0).
- R8: SMM accesses always reach RAM.
- R9: A non-SMM access inside an enabled window reaches RAM when open=1 and close=0.
- R10: While locked, writes to the window register and to the global enable bit are ignored. The close bit remains writable.
- R11: When the global enable or the window enable is 0, the whole address range is ordinary RAM.
- R12: After reset, both registers read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sel | input | 1 | Register select: 0 window, 1 control |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Selected register value |
| req_valid | input | 1 | Memory request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_smm | input | 1 | Request issued in system-management mode |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Read data, 0xFF when blocked |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |

## Verification
The hardest situation to reach is a locked register set that still holds a live window together with an attempt to weaken it. The window must be enabled and closed before the lock lands, and later writes must try to reopen it or shrink it. Random configuration writes rarely produce that order, because they set the lock early and freeze a useless setting. The directed part therefore programs each size code, closes the window, locks it and then probes the bytes at base-1, base and top-1. The random phase lowers the lock probability so that open, close and size combinations get explored first. It then mixes accesses aimed at the window edges.

// File: rtl/smram_pkg.sv
`timescale 1ns/1ps
package smram_pkg;

    localparam int MB_SHIFT = 20;

    typedef enum logic [1:0] {
        SZ_1MB = 2'b00,
        SZ_2MB = 2'b01,
        SZ_8MB = 2'b10,
        SZ_EXT = 2'b11
    } size_code_e;

    typedef struct packed {
        logic       win_en;
        size_code_e size;
    } win_cfg_t;

    typedef struct packed {
        logic gen_en;
        logic lock;
        logic close;
        logic open;
    } smm_ctl_t;

    localparam int BIT_OPEN  = 0;
    localparam int BIT_CLOSE = 1;
    localparam int BIT_LOCK  = 2;
    localparam int BIT_GEN   = 3;
    localparam int BIT_WEN   = 2;

    function automatic int unsigned size_mb(input size_code_e c, input int unsigned ext_mb);
        case (c)
            SZ_1MB:  return 1;
            SZ_2MB:  return 2;
            SZ_8MB:  return 8;
            default: return ext_mb;
        endcase
    endfunction

    function automatic logic [7:0] pack_win(input win_cfg_t w);
        return {5'b0, w.win_en, w.size};
    endfunction

    function automatic logic [7:0] pack_ctl(input smm_ctl_t c);
        return {4'b0, c.gen_en, c.lock, c.close, c.open};
    endfunction

endpackage

// File: rtl/smram_cfg_regs.sv
`timescale 1ns/1ps
module smram_cfg_regs
    import smram_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_sel,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    output win_cfg_t   win_o,
    output smm_ctl_t   ctl_o
);
    win_cfg_t win_q;
    smm_ctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
            ctl_q <= '0;
        end else if (cfg_we) begin
            if (!cfg_sel) begin
                if (!ctl_q.lock) begin
                    win_q.size   <= size_code_e'(cfg_wdata[1:0]);
                    win_q.win_en <= cfg_wdata[BIT_WEN];
                end
            end else if (ctl_q.lock) begin
                ctl_q.close <= cfg_wdata[BIT_CLOSE];
            end else begin
                ctl_q.open   <= cfg_wdata[BIT_OPEN] & ~cfg_wdata[BIT_LOCK];
                ctl_q.close  <= cfg_wdata[BIT_CLOSE];
                ctl_q.lock   <= cfg_wdata[BIT_LOCK];
                ctl_q.gen_en <= cfg_wdata[BIT_GEN];
            end
        end
    end

    always_comb begin
        smm_ctl_t shown;
        shown = ctl_q;
        if (ctl_q.lock) shown.open = 1'b0;
        cfg_rdata = cfg_sel ? pack_ctl(shown) : pack_win(win_q);
    end

    assign win_o = win_q;
    assign ctl_o = ctl_q;

    AST_LOCK_CLEARS_OPEN: assert property (@(posedge clk) disable iff (rst)
        ctl_q.lock |-> !ctl_q.open); // R2
    AST_LOCKED_OPEN_STAYS_LOW: assert property (@(posedge clk) disable iff (rst)
        ctl_q.lock && cfg_we && cfg_sel |=> !ctl_q.open); // R3
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        ctl_q.lock |=> ctl_q.lock); // R4
    AST_LOCKED_WIN_FROZEN: assert property (@(posedge clk) disable iff (rst)
        ctl_q.lock |=> $stable(win_q)); // R10
    AST_LOCKED_GEN_FROZEN: assert property (@(posedge clk) disable iff (rst)
        ctl_q.lock |=> $stable(ctl_q.gen_en)); // R10
endmodule

// File: rtl/smram_window_calc.sv
`timescale 1ns/1ps
module smram_window_calc
    import smram_pkg::*;
#(
    parameter int unsigned RAM_MB = 128,
    parameter int unsigned EXT_MB = 16,
    parameter int          ADDR_W = 27
)(
    input  win_cfg_t          win_i,
    output logic [ADDR_W:0]   base_o,
    output logic [ADDR_W:0]   top_o
);
    localparam int BW = ADDR_W + 1;

    int unsigned sz_mb;
    int unsigned base_mb;

    always_comb begin
        sz_mb   = size_mb(win_i.size, EXT_MB);
        base_mb = (sz_mb >= RAM_MB) ? 0 : RAM_MB - sz_mb;
        base_o  = BW'(base_mb) << MB_SHIFT;
        top_o   = BW'(RAM_MB) << MB_SHIFT;
    end
endmodule

// File: rtl/smram_access_filter.sv
`timescale 1ns/1ps
module smram_access_filter
    import smram_pkg::*;
#(
    parameter int ADDR_W = 27
)(
    input  logic              clk,
    input  logic              rst,
    input  win_cfg_t          win_i,
    input  smm_ctl_t          ctl_i,
    input  logic [ADDR_W:0]   base_i,
    input  logic [ADDR_W:0]   top_i,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_smm,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_wdata,
    output logic [7:0]        rsp_rdata,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata
);
    logic [ADDR_W:0] addr_x;
    logic armed, in_win, permit;

    always_comb begin
        addr_x    = {1'b0, req_addr};
        armed     = ctl_i.gen_en & win_i.win_en;
        in_win    = armed & (addr_x >= base_i) & (addr_x < top_i);
        permit    = !in_win | req_smm | (ctl_i.open & !ctl_i.close);
        ram_en    = req_valid & permit;
        ram_we    = req_valid & permit & req_write;
        ram_addr  = req_addr;
        ram_wdata = req_wdata;
        rsp_rdata = permit ? ram_rdata : 8'hFF;
    end

    AST_CLOSED_READ_ONES: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_write && !req_smm && ctl_i.gen_en && win_i.win_en && ctl_i.close
        && addr_x >= base_i && addr_x < top_i |-> rsp_rdata == 8'hFF); // R7
    AST_CLOSED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_write && !req_smm && ctl_i.gen_en && win_i.win_en && ctl_i.close
        && addr_x >= base_i && addr_x < top_i |-> !ram_we); // R7
    AST_SMM_PASSES: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_smm |-> ram_en); // R8
    AST_BELOW_BASE_PASSES: assert property (@(posedge clk) disable iff (rst)
        req_valid && (addr_x + 1'b1 == base_i) |-> ram_en); // R6
    AST_DISABLED_PASSES: assert property (@(posedge clk) disable iff (rst)
        req_valid && !(ctl_i.gen_en && win_i.win_en) |-> ram_en); // R11
endmodule

// File: rtl/smram_guard.sv
`timescale 1ns/1ps
module smram_guard
    import smram_pkg::*;
#(
    parameter int unsigned RAM_MB = 128,
    parameter int unsigned EXT_MB = 16,
    parameter int          ADDR_W = $clog2(RAM_MB) + 20
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_sel,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_smm,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_wdata,
    output logic [7:0]        rsp_rdata,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata
);
    win_cfg_t        win;
    smm_ctl_t        ctl;
    logic [ADDR_W:0] base;
    logic [ADDR_W:0] top;

    smram_cfg_regs u_regs (
        .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .win_o(win), .ctl_o(ctl)
    );

    smram_window_calc #(.RAM_MB(RAM_MB), .EXT_MB(EXT_MB), .ADDR_W(ADDR_W)) u_calc (
        .win_i(win), .base_o(base), .top_o(top)
    );

    smram_access_filter #(.ADDR_W(ADDR_W)) u_filter (
        .clk(clk), .rst(rst), .win_i(win), .ctl_i(ctl), .base_i(base), .top_i(top),
        .req_valid(req_valid), .req_write(req_write), .req_smm(req_smm),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );
endmodule

// File: tb/smram_guard_bench.sv
`timescale 1ns/1ps
module smram_guard_bench;
    localparam int unsigned RAM_MB = 128;
    localparam int unsigned EXT_MB = 16;
    localparam int          ADDR_W = 27;
    localparam int unsigned MB     = 1 << 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_sel = 1'b0, cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0, cfg_rdata;
    logic req_valid = 1'b0, req_write = 1'b0, req_smm = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0, ram_addr;
    logic [7:0] req_wdata = '0, rsp_rdata, ram_wdata, ram_rdata = '0;
    logic ram_en, ram_we;

    int tests = 0, fails = 0;
    bit done = 0;

    logic [7:0] ram [int unsigned];
    logic [7:0] refm [int unsigned];

    logic [1:0] m_size; logic m_wen, m_open, m_close, m_lock, m_gen;

    always #2.5 clk = ~clk;

    smram_guard #(.RAM_MB(RAM_MB), .EXT_MB(EXT_MB), .ADDR_W(ADDR_W)) u_smram_guard (
        .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_write(req_write),
        .req_smm(req_smm), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    function automatic logic [7:0] rd_ram(input int unsigned a);
        return ram.exists(a) ? ram[a] : 8'h00;
    endfunction
    function automatic logic [7:0] rd_ref(input int unsigned a);
        return refm.exists(a) ? refm[a] : 8'h00;
    endfunction
    function automatic int unsigned exp_size(input logic [1:0] c);
        case (c) 2'b00: return 1; 2'b01: return 2; 2'b10: return 8; default: return EXT_MB; endcase
    endfunction
    function automatic int unsigned exp_base();
        return (RAM_MB - exp_size(m_size)) * MB;
    endfunction
    function automatic bit exp_pass(input int unsigned a, input bit smm);
        bit inw;
        inw = m_gen && m_wen && a >= exp_base() && a < RAM_MB * MB;
        return !inw || smm || (m_open && !m_close);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_size = 0; m_wen = 0; m_open = 0; m_close = 0; m_lock = 0; m_gen = 0;
    endtask

    task automatic cfg_wr(input bit sel, input logic [7:0] d);
        @(negedge clk); cfg_sel = sel; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk); cfg_we = 1'b0;
        if (!sel) begin
            if (!m_lock) begin m_size = d[1:0]; m_wen = d[2]; end
        end else if (m_lock) m_close = d[1];
        else begin m_open = d[0] & ~d[2]; m_close = d[1]; m_lock = d[2]; m_gen = d[3]; end
    endtask

    task automatic cfg_rd(input bit sel, output logic [7:0] d);
        @(negedge clk); cfg_sel = sel; #1; d = cfg_rdata;
    endtask

    task automatic check_regs(input string req);
        logic [7:0] d;
        cfg_rd(1'b0, d); check(req, d, {5'b0, m_wen, m_size});
        cfg_rd(1'b1, d); check(req, d, {4'b0, m_gen, m_lock, m_close, m_open});
    endtask

    task automatic access(input string req, input int unsigned a, input bit wr,
                          input bit smm, input logic [7:0] wd);
        bit p;
        logic [7:0] exp_rd;
        p = exp_pass(a, smm);
        exp_rd = p ? rd_ref(a) : 8'hFF;
        @(negedge clk);
        req_addr = ADDR_W'(a); req_write = wr; req_smm = smm; req_wdata = wd; req_valid = 1'b1;
        ram_rdata = rd_ram(a);
        #1;
        check({req, " ram_en"}, ram_en, p);
        if (!wr) check({req, " rdata"}, rsp_rdata, exp_rd);
        if (ram_en && ram_we) ram[int'(ram_addr)] = ram_wdata;
        if (wr && p) refm[a] = wd;
        @(negedge clk); req_valid = 1'b0;
    endtask

    initial begin
        logic [7:0] d;
        int unsigned b;
        void'($urandom(32'd4242));
        m_size = 0; m_wen = 0; m_open = 0; m_close = 0; m_lock = 0; m_gen = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_regs("R12 reset");

        cfg_wr(1'b1, 8'h00); cfg_rd(1'b1, d); check("R1 open=0", d[0], 1'b0);
        cfg_wr(1'b1, 8'h01); cfg_rd(1'b1, d); check("R1 open=1", d[0], 1'b1);
        cfg_wr(1'b1, 8'h05); cfg_rd(1'b1, d); check("R2 lock clears open", d, 8'h04);
        cfg_wr(1'b1, 8'h01); cfg_rd(1'b1, d); check("R3 locked open ignored", d, 8'h04);
        cfg_wr(1'b0, 8'h07); cfg_rd(1'b0, d); check("R10 win frozen", d, 8'h00);
        cfg_wr(1'b1, 8'h0A); cfg_rd(1'b1, d); check("R10 gen frozen close writable", d, 8'h06);
        do_reset();
        cfg_rd(1'b1, d); check("R4 reset clears lock", d, 8'h00);
        cfg_wr(1'b1, 8'h01); cfg_rd(1'b1, d); check("R4 open writable again", d, 8'h01);

        for (int c = 0; c < 4; c++) begin
            do_reset();
            cfg_wr(1'b0, 8'(c) | 8'h04);
            check_regs("R5 size code readback");
            cfg_wr(1'b1, 8'h0A);
            cfg_wr(1'b1, 8'h0E);
            b = exp_base();
            check("R6 base value", b, (RAM_MB - exp_size(2'(c))) * MB);
            access("R6 below base read", b - 1, 0, 0, 0);
            access("R6 below base write", b - 1, 1, 0, 8'h01);
            access("R6 below base readback", b - 1, 0, 0, 0);
            access("R7 base read", b, 0, 0, 0);
            access("R7 base write", b, 1, 0, 8'h33);
            access("R7 base readback", b, 0, 0, 0);
            access("R7 top read", RAM_MB * MB - 1, 0, 0, 0);
            access("R8 smm write", b, 1, 1, 8'h5C);
            access("R8 smm read", b, 0, 1, 0);
            access("R7 hidden after smm write", b, 0, 0, 0);
        end

        do_reset();
        cfg_wr(1'b0, 8'h01); cfg_wr(1'b1, 8'h0A);
        access("R11 window disabled", (RAM_MB - 2) * MB, 1, 0, 8'h77);
        access("R11 window disabled read", (RAM_MB - 2) * MB, 0, 0, 0);
        cfg_wr(1'b0, 8'h05); cfg_wr(1'b1, 8'h01);
        access("R11 global disabled", (RAM_MB - 2) * MB, 0, 0, 0);
        cfg_wr(1'b1, 8'h09);
        access("R9 open passes", (RAM_MB - 2) * MB, 0, 0, 0);
        cfg_wr(1'b1, 8'h0B);
        access("R7 open and close blocks", (RAM_MB - 2) * MB, 0, 0, 0);

        for (int i = 0; i < 600; i++) begin
            int unsigned r, a;
            r = $urandom % 20;
            if (r == 0) do_reset();
            else if (r < 6) begin
                d = 8'($urandom);
                if (d[2] && ($urandom % 6 != 0)) d[2] = 1'b0;
                cfg_wr(1'(r % 2), d);
                check_regs("R1 R3 R10 random cfg");
            end else begin
                b = exp_base();
                case ($urandom % 5)
                    0: a = b - 1;
                    1: a = b;
                    2: a = RAM_MB * MB - 1;
                    3: a = b + ($urandom % (RAM_MB * MB - b));
                    default: a = $urandom % (RAM_MB * MB);
                endcase
                access("R7 R8 R9 R11 random access", a, 1'($urandom), 1'($urandom % 3 == 0), 8'($urandom));
            end
        end

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule